// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two independent timers. Each has a 16-bit count kept as a high byte and a low byte. A shared mode byte and a shared control byte govern both. A timer advances either on a prescaled tick, which fires once every `PRESCALE` system clocks, or on falling edges of an external count pin. Counting is enabled by a run bit, optionally qualified by a gate pin. When a count rolls over, the timer raises its overflow flag, which serves as an interrupt request. Software clears a flag by writing the control byte, or the interrupt logic clears it by pulsing an acknowledge input.

Each timer offers four modes: a 13-bit count, a 16-bit count, an 8-bit count that reloads from the high byte, and a split mode. In split mode timer 0 becomes two 8-bit counters. Its high-byte counter takes over timer 1's run bit and overflow flag. Registers are written through a simple write port and read back combinationally through an address-selected read port.

Top module: `twin_timer`

Register map (address: contents):
- 0: timer 0 low byte
- 1: timer 0 high byte
- 2: timer 1 low byte
- 3: timer 1 high byte
- 4: mode byte. Bits [3:0] belong to timer 0 and bits [7:4] to timer 1. Within each nibble, bit 3 is gate enable, bit 2 selects counter (1) or timer (0), and bits 1:0 select the mode.
- 5: control byte. Bit 0 is run0, bit 1 is run1, bit 4 is flag0 and bit 5 is flag1.

## Requirements
- R1: In timer operation a running timer advances by one on each prescaled tick. The tick occurs on the PRESCALE-th rising clock edge after reset release and every PRESCALE edges after that, so K ticks fall in any window of K*PRESCALE edges.
- R2: In counter operation (mode bit 2 set) a running timer advances once for each 1-to-0 transition of its count pin. Pin levels are synchronised and sampled on the tick, and nothing else advances the count.
- R3: A timer counts only while its run bit is 1 and either its gate-enable bit is 0 or its gate pin is high. Otherwise its count holds.
- R4: In mode 0 the count is 13 bits wide: the high byte above the low 5 bits of the low byte. The low byte's upper 3 bits are left unchanged. A count of 0x1FFF rolls over to 0 and sets the flag.
- R5: In mode 1 the count is 16 bits wide. A rollover from 0xFFFF to 0x0000 sets the timer's flag, which appears on `ovfFlag` and in the control byte.
- R6: In mode 2 the low byte counts. When it rolls over from 0xFF, it is loaded from the high byte, the high byte is unchanged, and the flag is set.
- R7: While timer 0 is in mode 3, its low byte counts under timer 0's controls and sets flag0. Its high byte advances on every tick while run1 is 1 and sets flag1 on rollover. Timer 1 keeps counting in its own mode but never sets flag1. A timer 1 in mode 3 holds its count.
- R8: A 1 on `ackIrq[i]` clears flag i. Writing the control byte loads both flags from bits 5:4. An overflow in the same cycle as an acknowledge leaves the flag set.
- R9: After reset every register reads 0 and both flags are 0. A written register reads back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntPin | input | 2 | External count pins, bit i for timer i |
| gatePin | input | 2 | Gate pins, bit i for timer i |
| ackIrq | input | 2 | Flag acknowledge, bit i clears flag i |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 8 | Register read data (combinational) |
| ovfFlag | output | 2 | Overflow flags, used as interrupt requests |

## Verification
The checks assume that gate pins and acknowledges are synchronous to `clk`. They also assume that a register write in a cycle takes precedence over counting, so each assertion that follows a count or a flag across an edge excuses cycles carrying `wrEn`. The stimulus changes every input on the falling clock edge. It holds each count-pin level for more than two prescaler periods, so every falling edge is seen exactly once. It starts each timed window from a known prescaler phase, which keeps every sampled count exact.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;

  localparam logic [2:0] ADDR_LO0  = 3'd0;
  localparam logic [2:0] ADDR_HI0  = 3'd1;
  localparam logic [2:0] ADDR_LO1  = 3'd2;
  localparam logic [2:0] ADDR_HI1  = 3'd3;
  localparam logic [2:0] ADDR_MODE = 3'd4;
  localparam logic [2:0] ADDR_CTRL = 3'd5;

  typedef struct packed {
    logic stepLo0;  // timer 0 main count step
    logic stepHi0;  // timer 0 high byte step in split mode
    logic step1;    // timer 1 count step
  } stepStrobe_t;

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
    logic       ovf;
  } cntNext_t;

  function automatic cntNext_t advance(input logic [1:0] mode,
                                       input logic [7:0] hi,
                                       input logic [7:0] lo);
    cntNext_t r;
    r.hi  = hi;
    r.lo  = lo;
    r.ovf = 1'b0;
    case (mode)
      2'd0: {r.ovf, r.hi, r.lo[4:0]} = {1'b0, hi, lo[4:0]} + 14'd1;
      2'd1: {r.ovf, r.hi, r.lo} = {1'b0, hi, lo} + 17'd1;
      2'd2: begin
        {r.ovf, r.lo} = {1'b0, lo} + 9'd1;
        if (r.ovf) r.lo = hi;
      end
      default: {r.ovf, r.lo} = {1'b0, lo} + 9'd1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/twin_timer_ctrl.sv
module twin_timer_ctrl
  import twin_timer_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_TMR     = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_TMR-1:0] cntPin,
  input  logic [NUM_TMR-1:0] gatePin,
  input  logic [7:0]         modeReg,
  input  logic [NUM_TMR-1:0] runBits,
  output stepStrobe_t        stb
);
  localparam int PS_W = $clog2(PRESCALE);
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0]    psCnt;
  logic               tick;
  logic [NUM_TMR-1:0] fallEdge;
  logic [NUM_TMR-1:0] srcPulse;
  logic [NUM_TMR-1:0] gateOk;
  logic               split;

  assign tick = (psCnt == PS_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     psCnt <= '0;
    else if (tick) psCnt <= '0;
    else           psCnt <= psCnt + 1'b1;
  end

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_pin
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   lastSmp;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ   <= '0;
        lastSmp <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], cntPin[gi]};
        if (tick) lastSmp <= syncQ[SYNC_STAGES-1];
      end
    end
    assign fallEdge[gi] = tick & lastSmp & ~syncQ[SYNC_STAGES-1];
    assign srcPulse[gi] = modeReg[4*gi+2] ? fallEdge[gi] : tick;
    assign gateOk[gi]   = ~modeReg[4*gi+3] | gatePin[gi];
  end

  assign split       = (modeReg[1:0] == 2'd3);
  assign stb.stepLo0 = srcPulse[0] & runBits[0] & gateOk[0];
  assign stb.stepHi0 = split & tick & runBits[1];
  assign stb.step1   = srcPulse[1] & runBits[1] & gateOk[1] & (modeReg[5:4] != 2'd3);

  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  p_count_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepLo0 || stb.stepHi0 || stb.step1) |-> tick);

endmodule

// File: rtl/twin_timer_dp.sv
module twin_timer_dp
  import twin_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  stepStrobe_t stb,
  input  logic [1:0]  ackIrq,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic [2:0]  rdAddr,
  output logic [7:0]  rdData,
  output logic [7:0]  modeQ,
  output logic [1:0]  runQ,
  output logic [1:0]  tfQ
);
  logic [7:0] lo0, hi0, lo1, hi1;
  cntNext_t   nx0, nx1;
  logic [8:0] hiInc;
  logic       split, set0, set1;

  always_comb begin
    nx0   = advance(modeQ[1:0], hi0, lo0);
    nx1   = advance(modeQ[5:4], hi1, lo1);
    hiInc = {1'b0, hi0} + 9'd1;
    split = (modeQ[1:0] == 2'd3);
    set0  = stb.stepLo0 & nx0.ovf;
    set1  = split ? (stb.stepHi0 & hiInc[8]) : (stb.step1 & nx1.ovf);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lo0 <= '0; hi0 <= '0; lo1 <= '0; hi1 <= '0;
      modeQ <= '0; runQ <= '0; tfQ <= '0;
    end else begin
      if (stb.stepLo0) lo0 <= nx0.lo;
      if (stb.stepHi0) hi0 <= hiInc[7:0];
      else if (stb.stepLo0) hi0 <= nx0.hi;
      if (stb.step1) begin
        lo1 <= nx1.lo;
        hi1 <= nx1.hi;
      end
      tfQ <= (tfQ & ~ackIrq) | {set1, set0};
      if (wrEn) begin
        case (wrAddr)
          ADDR_LO0:  lo0 <= wrData;
          ADDR_HI0:  hi0 <= wrData;
          ADDR_LO1:  lo1 <= wrData;
          ADDR_HI1:  hi1 <= wrData;
          ADDR_MODE: modeQ <= wrData;
          ADDR_CTRL: begin
            runQ <= wrData[1:0];
            tfQ  <= wrData[5:4];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_LO0:  rdData = lo0;
      ADDR_HI0:  rdData = hi0;
      ADDR_LO1:  rdData = lo1;
      ADDR_HI1:  rdData = hi1;
      ADDR_MODE: rdData = modeQ;
      ADDR_CTRL: rdData = {2'b00, tfQ, 2'b00, runQ};
      default:   rdData = '0;
    endcase
  end

  p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ[0] && !wrEn) |=> $stable(lo0));

  p_ovf_sets_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[1:0] == 2'd1 && stb.stepLo0 && lo0 == 8'hFF && hi0 == 8'hFF && !wrEn)
      |=> tfQ[0]);

  p_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[1:0] == 2'd2 && stb.stepLo0 && lo0 == 8'hFF && !wrEn)
      |=> (lo0 == $past(hi0)));

  p_split_tf1_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ[1:0] == 2'd3 && !stb.stepHi0 && !tfQ[1] && !wrEn) |=> !tfQ[1]);

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackIrq[0] && !stb.stepLo0 && !wrEn) |=> !tfQ[0]);

endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import twin_timer_pkg::*;
#(
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cntPin,
  input  logic [1:0] gatePin,
  input  logic [1:0] ackIrq,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData,
  output logic [1:0] ovfFlag
);
  stepStrobe_t stb;
  logic [7:0]  modeQ;
  logic [1:0]  runQ;

  twin_timer_ctrl #(
    .PRESCALE(PRESCALE), .SYNC_STAGES(SYNC_STAGES), .NUM_TMR(2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cntPin(cntPin), .gatePin(gatePin),
    .modeReg(modeQ), .runBits(runQ), .stb(stb)
  );

  twin_timer_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ackIrq(ackIrq),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .modeQ(modeQ), .runQ(runQ), .tfQ(ovfFlag)
  );

endmodule

// File: tb/sim_twin_timer.sv
module sim_twin_timer;
  localparam int PS = 12;
  localparam int SEL_FLAGS = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] cntPin = '0, gatePin = '0, ackIrq = '0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [1:0] ovfFlag;

  int nChecks = 0, nFails = 0, edgeCnt = 0;
  bit finished = 0;

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  twin_timer #(.PRESCALE(PS)) u0 (
    .clk(clk), .rstN(rstN), .cntPin(cntPin), .gatePin(gatePin), .ackIrq(ackIrq),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .ovfFlag(ovfFlag)
  );

  always @(posedge clk) if (!rstN) edgeCnt <= 0; else edgeCnt <= edgeCnt + 1;

  // Monitor: compares queued expectations with what the design shows
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = q.pop_front();
      act = (it.sel == SEL_FLAGS) ? {6'b0, ovfFlag} : rdData;
      nChecks++;
      if (act !== it.exp) begin
        nFails++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  // Driver: present a read and queue its expected value
  task automatic expect_val(input int sel, input logic [7:0] exp, input string tag);
    item_t it;
    if (sel != SEL_FLAGS) rdAddr = 3'(sel);
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic sync_phase();
    @(negedge clk);
    while (edgeCnt % PS != 0) @(negedge clk);
  endtask

  task automatic run_ticks(input logic [7:0] ctrl, input int k);
    sync_phase();
    wr(3'd5, ctrl);
    repeat (PS * k) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    for (int a = 0; a < 6; a++) expect_val(a, 8'h00, "R9 reset");
    expect_val(SEL_FLAGS, 8'h00, "R9 reset flags");
    wr(3'd2, 8'h5A);
    expect_val(2, 8'h5A, "R9 readback");

    // R1 timer mode, both timers in mode 1
    wr(3'd4, 8'h11); wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    run_ticks(8'h03, 20);
    expect_val(0, 8'h14, "R1 t0 count");
    expect_val(2, 8'h14, "R1 t1 count");
    expect_val(1, 8'h00, "R1 t0 high");
    wr(3'd5, 8'h00);

    // R5 mode 1 rollover
    wr(3'd4, 8'h01); wr(3'd1, 8'hFF); wr(3'd0, 8'hFD);
    run_ticks(8'h01, 3);
    expect_val(0, 8'h00, "R5 low");
    expect_val(1, 8'h00, "R5 high");
    expect_val(SEL_FLAGS, 8'h01, "R5 flag");
    expect_val(5, 8'h11, "R5 ctrl byte");

    // R8 acknowledge and write clear
    ackIrq = 2'b01;
    @(negedge clk);
    ackIrq = 2'b00;
    expect_val(SEL_FLAGS, 8'h00, "R8 ack clear");
    wr(3'd5, 8'h20);
    expect_val(SEL_FLAGS, 8'h02, "R8 write load");
    wr(3'd5, 8'h00);
    expect_val(SEL_FLAGS, 8'h00, "R8 write clear");

    // R4 mode 0: carry from bit 4, then 13-bit rollover
    wr(3'd4, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h3F);
    run_ticks(8'h01, 1);
    expect_val(0, 8'h20, "R4 carry low");
    expect_val(1, 8'h01, "R4 carry high");
    wr(3'd5, 8'h00);
    wr(3'd1, 8'hFF); wr(3'd0, 8'hFE);
    run_ticks(8'h01, 2);
    expect_val(0, 8'hE0, "R4 wrap low");
    expect_val(1, 8'h00, "R4 wrap high");
    expect_val(SEL_FLAGS, 8'h01, "R4 flag");
    wr(3'd5, 8'h00);

    // R6 mode 2 reload
    wr(3'd4, 8'h02); wr(3'd1, 8'hA0); wr(3'd0, 8'hFE);
    run_ticks(8'h01, 3);
    expect_val(0, 8'hA1, "R6 reloaded low");
    expect_val(1, 8'hA0, "R6 high kept");
    expect_val(SEL_FLAGS, 8'h01, "R6 flag");
    wr(3'd5, 8'h00);

    // R7 split mode, timer 1 overflows silently
    wr(3'd4, 8'h13); wr(3'd0, 8'hFE); wr(3'd1, 8'h10); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    run_ticks(8'h03, 3);
    expect_val(0, 8'h01, "R7 t0 low");
    expect_val(1, 8'h13, "R7 t0 high");
    expect_val(2, 8'h02, "R7 t1 low");
    expect_val(3, 8'h00, "R7 t1 high");
    expect_val(SEL_FLAGS, 8'h01, "R7 flags no t1");
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h00); wr(3'd1, 8'hFE);
    run_ticks(8'h03, 3);
    expect_val(1, 8'h01, "R7 t0 high wrap");
    expect_val(0, 8'h03, "R7 t0 low");
    expect_val(SEL_FLAGS, 8'h02, "R7 flag1 from high");
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h31); wr(3'd2, 8'h05);
    run_ticks(8'h02, 3);
    expect_val(2, 8'h05, "R7 t1 mode3 holds");
    wr(3'd5, 8'h00);

    // R2 counter mode on pin 0
    wr(3'd4, 8'h05); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    repeat (40) @(negedge clk);
    wr(3'd5, 8'h01);
    for (int i = 0; i < 5; i++) begin
      cntPin[0] = 1'b1; repeat (30) @(negedge clk);
      cntPin[0] = 1'b0; repeat (30) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    expect_val(0, 8'h05, "R2 five edges");
    repeat (100) @(negedge clk);
    expect_val(0, 8'h05, "R2 no pin activity");
    wr(3'd5, 8'h00);

    // R3 gate and run
    wr(3'd4, 8'h09); wr(3'd0, 8'h00);
    run_ticks(8'h01, 10);
    expect_val(0, 8'h00, "R3 gate low blocks");
    sync_phase();
    gatePin[0] = 1'b1;
    repeat (PS * 10) @(negedge clk);
    expect_val(0, 8'h0A, "R3 gate high counts");
    wr(3'd5, 8'h00);
    repeat (60) @(negedge clk);
    expect_val(0, 8'h0A, "R3 run off holds");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule